// File: doc/BRIEF.md
# Tick-Sampled Asymmetric Pin Debouncer

This block cleans up one slow, noisy input pin. The raw pin first passes through a two-flop synchronizer. After that, the block samples it only on cycles where a periodic tick strobe is high. A tick every millisecond is typical. The block keeps a stable level, and that level changes only after a run of consecutive ticks on which the sample disagrees with it. The run needed to go from low to high and the run needed to go from high to low are separate parameters. Any single agreeing sample restarts the run from the full count for the current level.

Each time the stable level changes, the block can raise a one-cycle event. In normal mode the event fires on a change to high. In active-low mode it fires on a change to low, and the level output is inverted. In both-edges mode it fires on every change. Once a change completes, the block watches for movement in the opposite direction.

When debouncing is switched off, the output is the synchronized raw pin, inverted in active-low mode, and no events are raised. While debouncing is off, the stable level keeps loading from the pin. Turning debouncing on therefore starts from the pin's current level. The block has no data stream, so every pin is a plain control or status signal with no handshake.

Top module: `tick_debouncer`

## Requirements
- R1: After reset, with the pin low and active-low off, `level` is 0 and `evt` is 0.
- R2: With `dbn_en` low, `level` equals the synchronized pin XOR `act_low`, and `evt` stays 0.
- R3: A pin change reaches `level` through exactly two clock edges of synchronization. With `dbn_en` low, `level` still shows the old value after the first edge and the new value after the second.
- R4: A low-to-high change commits on the RISE_TICKS-th consecutive tick whose sample is high. Fewer such ticks leave the stable level low.
- R5: A high-to-low change commits on the FALL_TICKS-th consecutive tick whose sample is low. Fewer such ticks leave the stable level high.
- R6: A tick whose sample equals the stable level reloads the run count for that level. Disagreeing ticks separated by an agreeing tick do not add up.
- R7: Cycles without a tick never change the stable level, whatever the pin does.
- R8: With `both_edges`=0 and `act_low`=0, `evt` pulses on a commit to high and never on a commit to low.
- R9: With `both_edges`=0 and `act_low`=1, `evt` pulses on a commit to low and never on a commit to high, and `level` is the inverted stable level.
- R10: With `both_edges`=1, `evt` pulses on every commit in either direction.
- R11: `evt` is high for exactly one clock cycle. It rises on the same clock edge that updates `level`, which is the edge that sampled the committing tick.
- R12: When `dbn_en` rises, the stable level is the pin's current synchronized value, and no event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle sample strobe |
| pin_raw | input | 1 | Asynchronous raw pin |
| dbn_en | input | 1 | 1 = debounce, 0 = pass the synchronized pin through |
| act_low | input | 1 | Active-low mode: inverts `level` and selects the falling commit as the event |
| both_edges | input | 1 | Raise an event on commits in both directions |
| level | output | 1 | Debounced (or passed-through) level after the polarity option |
| evt | output | 1 | One-cycle pulse on a qualified commit |

## Verification
The assertions check four things on every cycle. An event only follows a tick. The level stays put between ticks while debouncing. No event appears while debouncing is off or in the cycle it is enabled. In single-edge modes, an event always coincides with the output reading as asserted. The exact tick counts for each direction, the restart of the run after an agreeing sample, the two-edge synchronizer latency and the choice of edge for each mode can only be shown by the bench. It sweeps every mode combination over glitch lengths and compares the results with a tick-by-tick arithmetic model.

// File: rtl/tdb_pkg.sv
package tdb_pkg;
  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/tdb_sync.sv
module tdb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end
  assign q = sh[STAGES-1];
endmodule

// File: rtl/tdb_core.sv
module tdb_core #(
  parameter int unsigned RISE_TICKS = 2,
  parameter int unsigned FALL_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  input  logic s_in,
  output logic stab,
  output logic commit_q
);
  localparam int unsigned MAXT  = tdb_pkg::max_u(RISE_TICKS, FALL_TICKS);
  localparam int unsigned CNT_W = $clog2(MAXT + 1);
  localparam logic [CNT_W-1:0] RISE_C = CNT_W'(RISE_TICKS);
  localparam logic [CNT_W-1:0] FALL_C = CNT_W'(FALL_TICKS);
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] reload_now;
  logic [CNT_W-1:0] reload_new;

  // stable low: next change is a rise; stable high: next change is a fall
  assign reload_now = stab ? FALL_C : RISE_C;
  assign reload_new = s_in ? FALL_C : RISE_C;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stab     <= 1'b0;
      cnt      <= RISE_C;
      commit_q <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      if (!en) begin
        stab <= s_in;
        cnt  <= reload_new;
      end else if (tick) begin
        if (s_in == stab) begin
          cnt <= reload_now;
        end else if (cnt == ONE_C) begin
          stab     <= s_in;
          cnt      <= reload_new;
          commit_q <= 1'b1;
        end else begin
          cnt <= cnt - ONE_C;
        end
      end
    end
  end
endmodule

// File: rtl/tick_debouncer.sv
module tick_debouncer #(
  parameter int unsigned RISE_TICKS  = 2,
  parameter int unsigned FALL_TICKS  = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin_raw,
  input  logic dbn_en,
  input  logic act_low,
  input  logic both_edges,
  output logic level,
  output logic evt
);
  logic s_in;
  logic stab;
  logic commit_q;

  tdb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(s_in)
  );

  tdb_core #(.RISE_TICKS(RISE_TICKS), .FALL_TICKS(FALL_TICKS)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(dbn_en), .s_in(s_in),
    .stab(stab), .commit_q(commit_q)
  );

  // stab XOR act_low is 1 exactly when the new level is the active one
  assign level = (dbn_en ? stab : s_in) ^ act_low;
  assign evt   = commit_q & (both_edges | (stab ^ act_low));
endmodule

// File: rtl/tdb_checker.sv
module tdb_checker (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic pin_raw,
  input logic dbn_en,
  input logic act_low,
  input logic both_edges,
  input logic level,
  input logic evt
);
  logic unused_pin;
  assign unused_pin = pin_raw;

  // R11: an event only follows a sampled tick
  a_r11_evt_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> $past(tick));

  // R7: no tick, no change while debouncing
  a_r7_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (dbn_en && $past(dbn_en) && !$past(tick) && $stable(act_low)) |-> $stable(level));

  // R2: disabled mode raises no event
  a_r2_no_evt_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbn_en && !$past(dbn_en)) |-> !evt);

  // R12: enabling never raises an event
  a_r12_quiet_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbn_en) |-> !evt);

  // R8 / R9: single-edge events coincide with the asserted output
  a_r8_active_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !both_edges && dbn_en && $past(dbn_en) && $stable(act_low) && $stable(both_edges))
      |-> level);
endmodule

bind tick_debouncer tdb_checker u_chk (.*);

// File: tb/sim_tick_debouncer.sv
module sim_tick_debouncer;
  localparam int RISE = 2;
  localparam int FALL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic pin_raw = 1'b0;
  logic dbn_en = 1'b0;
  logic act_low = 1'b0;
  logic both_edges = 1'b0;
  logic level;
  logic evt;

  int total = 0;
  int bad = 0;
  logic m_st = 1'b0;
  int   m_cnt = RISE;
  logic m_ev = 1'b0;

  always #10 clk = ~clk;

  tick_debouncer #(.RISE_TICKS(RISE), .FALL_TICKS(FALL)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pin_raw(pin_raw), .dbn_en(dbn_en),
    .act_low(act_low), .both_edges(both_edges), .level(level), .evt(evt)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk) pin_raw = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic model_reload();
    m_st  = pin_raw;
    m_cnt = pin_raw ? FALL : RISE;
  endtask

  // one tick with the arithmetic model; pin must be settled
  task automatic do_tick();
    m_ev = 1'b0;
    if (pin_raw == m_st) begin
      m_cnt = m_st ? FALL : RISE;
    end else begin
      m_cnt = m_cnt - 1;
      if (m_cnt == 0) begin
        m_st  = pin_raw;
        m_cnt = m_st ? FALL : RISE;
        m_ev  = both_edges | (m_st ^ act_low);
      end
    end
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    check("R4/R5/R6/R9 level", level, m_st ^ act_low);
    check("R8/R9/R10 evt", evt, m_ev);
    @(negedge clk);
    check("R11 evt one cycle", evt, 1'b0);
  endtask

  task automatic enable_fresh(input logic al, input logic be);
    @(negedge clk) begin dbn_en = 1'b0; act_low = al; both_edges = be; end
    set_pin(1'b0);
    @(negedge clk) dbn_en = 1'b1;
    model_reload();
    @(negedge clk);
  endtask

  initial begin
    #(20ns * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 level after reset", level, 1'b0);
    check("R1 evt after reset", evt, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R1 level out of reset", level, 1'b0);

    // R3: two-edge sync latency in pass-through
    @(negedge clk) pin_raw = 1'b1;
    @(negedge clk);
    check("R3 after one edge", level, 1'b0);
    @(negedge clk);
    check("R3 after two edges", level, 1'b1);
    // R2: pass-through with inversion, no events
    @(negedge clk) act_low = 1'b1;
    @(negedge clk);
    check("R2 inverted pass", level, 1'b0);
    check("R2 no evt", evt, 1'b0);
    set_pin(1'b0);
    check("R2 inverted pass low", level, 1'b1);
    check("R2 no evt low", evt, 1'b0);

    // sweep modes and glitch lengths
    for (int al = 0; al < 2; al++) begin
      for (int be = 0; be < 2; be++) begin
        enable_fresh(al[0], be[0]);
        for (int len = 1; len <= 4; len++) begin
          set_pin(m_st);
          do_tick();
          set_pin(~m_st);
          for (int k = 0; k < len; k++) do_tick();
          set_pin(~pin_raw);
          do_tick();
          do_tick();
        end
      end
    end

    // R4 directed: rise needs exactly RISE ticks
    enable_fresh(1'b0, 1'b0);
    set_pin(1'b1);
    do_tick();
    check("R4 one tick short", level, 1'b0);
    do_tick();
    check("R4 committed", level, 1'b1);
    // R5 directed: fall needs exactly FALL ticks, R6 interrupted run restarts
    set_pin(1'b0);
    do_tick(); do_tick();
    set_pin(1'b1);
    do_tick();
    set_pin(1'b0);
    do_tick(); do_tick();
    check("R6 restarted run not done", level, 1'b1);
    do_tick();
    check("R5 committed after FALL", level, 1'b0);

    // R7: pin moves without ticks
    set_pin(1'b1);
    repeat (20) @(negedge clk);
    check("R7 held without tick", level, 1'b0);
    check("R7 no evt without tick", evt, 1'b0);

    // R12: enable with pin high loads high, no event
    @(negedge clk) dbn_en = 1'b0;
    @(negedge clk) dbn_en = 1'b1;
    check("R12 no evt on enable", evt, 1'b0);
    @(negedge clk);
    check("R12 loaded level", level, 1'b1);
    model_reload();
    do_tick();
    check("R12 no commit after load", level, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule